// File: doc/BRIEF.md
# Prioritized Interrupt Status Register

This block gathers the six interrupt sources of one serial channel and resolves them by a fixed priority. Each request line sets a pending latch. Software reads a status byte that names the highest-priority pending source that is enabled. A single interrupt output is high while any enabled source is pending. The block does not produce the source conditions and does not decode the bus.

A read strobe clears only the source that the byte names in that cycle. The other latches keep their state, so the next read shows the next source in priority order. An enable bit hides its source from both the status byte and the interrupt output. The latch behind a disabled source keeps its state, so the source is reported again when it is re-enabled.

Top module: `isr_status_reg`

## Requirements
- R1: A synchronous reset clears every pending latch. After reset the status byte is 0x01 and `irq_o` is 0.
- R2: A request held high for one clock cycle sets that source's latch. The latch stays set, with no further request, until a read clears it.
- R3: The priority runs from request bit 0 (highest) to bit 5 (lowest). The status codes are: bit 0 line error 0x06, bit 1 receive timeout 0x0C, bit 2 receive data 0x04, bit 3 transmit empty 0x02, bit 4 modem change 0x00, bit 5 special event 0x10. The byte is 0x01 when nothing is reported. Bit 0 of the byte is 0 whenever a source is reported.
- R4: A read clears only the source the byte shows in the read cycle. The byte then shows the next lower-priority pending source.
- R5: A request that arrives in a read cycle does not change which source that read clears. A higher-priority source arriving in that cycle is shown after the read.
- R6: A disabled source is not reported and does not drive `irq_o`. Its latch keeps its state and the source is reported again once it is re-enabled.
- R7: `irq_o` is 1 exactly when the status byte reports a source.
- R8: A read when nothing is reported has no effect.
- R9: A request for the same source that a read clears in the same cycle wins, and the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 6 | Source requests, bit 0 has the highest priority |
| en_i | input | 6 | Source enables |
| rd_i | input | 1 | Status read strobe, one cycle per read |
| stat_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench raises a single source, then stacks a higher source above a lower one, then raises all six and drains them one read at a time. This separates correct priority and code values from a clear that drops too many latches or the wrong one. Some reads coincide with a new request: one case has a higher-priority arrival and another re-raises the source being cleared. These tell a read that captures its source from one that tracks the live request lines, and show whether set beats clear. Enable patterns mask a pending source, remove every enable, and then restore them. They show that masking hides a source without losing it and that a read with nothing shown clears nothing.

// File: rtl/isr_pkg.sv
package isr_pkg;

    localparam int NSRC   = 6;
    localparam int IDX_W  = 3;
    localparam int STAT_W = 8;

    typedef enum logic [IDX_W-1:0] {
        SRC_LINE_ERR = 3'd0,
        SRC_RX_TMO   = 3'd1,
        SRC_RX_DATA  = 3'd2,
        SRC_TX_EMPTY = 3'd3,
        SRC_MODEM    = 3'd4,
        SRC_SPECIAL  = 3'd5
    } src_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    localparam logic [STAT_W-1:0] STAT_IDLE = 8'h01;

    function automatic logic [STAT_W-1:0] code_of(pick_t p);
        logic [STAT_W-1:0] c;
        if (!p.valid) begin
            c = STAT_IDLE;
        end else begin
            case (src_e'(p.idx))
                SRC_LINE_ERR: c = 8'h06;
                SRC_RX_TMO:   c = 8'h0C;
                SRC_RX_DATA:  c = 8'h04;
                SRC_TX_EMPTY: c = 8'h02;
                SRC_MODEM:    c = 8'h00;
                SRC_SPECIAL:  c = 8'h10;
                default:      c = STAT_IDLE;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/isr_pend_bank.sv
module isr_pend_bank #(
    parameter int N = isr_pkg::NSRC
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                pend_o[g] <= 1'b0;
            end else if (set_i[g]) begin
                pend_o[g] <= 1'b1;
            end else if (clr_i[g]) begin
                pend_o[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/isr_prio_pick.sv
module isr_prio_pick #(
    parameter int N = isr_pkg::NSRC
) (
    input  logic [N-1:0]  cand_i,
    output isr_pkg::pick_t pick_o
);
    always_comb begin
        pick_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                pick_o.valid = 1'b1;
                pick_o.idx   = i[isr_pkg::IDX_W-1:0];
            end
        end
    end
endmodule

// File: rtl/isr_status_reg.sv
module isr_status_reg
    import isr_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [N-1:0]      req_i,
    input  logic [N-1:0]      en_i,
    input  logic              rd_i,
    output logic [STAT_W-1:0] stat_o,
    output logic              irq_o
);
    logic [N-1:0] pend;
    logic [N-1:0] visible;
    logic [N-1:0] clr;
    pick_t        pick;

    assign visible = pend & en_i;

    isr_prio_pick #(.N(N)) u_pick (
        .cand_i (visible),
        .pick_o (pick)
    );

    // clear targets the source shown in the read cycle, taken from latched state
    always_comb begin
        clr = '0;
        if (rd_i && pick.valid) begin
            clr = N'(1) << pick.idx;
        end
    end

    isr_pend_bank #(.N(N)) u_bank (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .set_i  (req_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    assign stat_o = code_of(pick);
    assign irq_o  = pick.valid;
endmodule

// File: rtl/isr_status_chk.sv
module isr_status_chk #(
    parameter int N = isr_pkg::NSRC
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic [N-1:0] en_i,
    input logic         rd_i,
    input logic [7:0]   stat_o,
    input logic         irq_o,
    input logic [N-1:0] pend_i
);
    // R1
    p_reset_idle_r1: assert property (@(posedge clk_i)
        rst_i |=> (stat_o == 8'h01 && !irq_o));

    // R7
    p_irq_matches_status_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o == !stat_o[0]);

    // R2
    p_latch_holds_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_i |=> ((pend_i & $past(pend_i)) == $past(pend_i)));

    // R4
    p_single_clear_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_i |=> ($countones($past(pend_i) & ~pend_i) <= 1));

    // R6
    p_masked_silent_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i == '0) |-> (stat_o == 8'h01 && !irq_o));

    // R8
    p_idle_read_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && stat_o[0]) |=> (pend_i & $past(pend_i)) == $past(pend_i));
endmodule

bind isr_status_reg isr_status_chk #(.N(N)) u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_i),
    .rd_i   (rd_i),
    .stat_o (stat_o),
    .irq_o  (irq_o),
    .pend_i (pend)
);

// File: tb/isr_status_reg_test.sv
module isr_status_reg_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] req;
    logic [5:0] en;
    logic       rd;
    logic [7:0] stat;
    logic       irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    isr_status_reg uut (
        .clk_i (clk), .rst_i (rst), .req_i (req), .en_i (en),
        .rd_i (rd), .stat_o (stat), .irq_o (irq)
    );

    // {req, en, rd, expected status, expected irq}
    localparam int NV = 26;
    localparam logic [21:0] VEC [0:NV-1] = '{
        {6'b100000, 6'h3F, 1'b0, 8'h10, 1'b1},  // R2 special alone
        {6'b001000, 6'h3F, 1'b0, 8'h02, 1'b1},  // R3 tx empty above special
        {6'b000000, 6'h3F, 1'b0, 8'h02, 1'b1},  // R2 held
        {6'b000000, 6'h3F, 1'b1, 8'h10, 1'b1},  // R4 next shown
        {6'b000000, 6'h3F, 1'b1, 8'h01, 1'b0},  // R4 drained
        {6'b000000, 6'h3F, 1'b1, 8'h01, 1'b0},  // R8 idle read
        {6'b111111, 6'h3F, 1'b0, 8'h06, 1'b1},  // R3 line error
        {6'b000000, 6'h3F, 1'b1, 8'h0C, 1'b1},  // R3 timeout
        {6'b000000, 6'h3F, 1'b1, 8'h04, 1'b1},  // R3 rx data
        {6'b000000, 6'h3F, 1'b1, 8'h02, 1'b1},  // R3 tx empty
        {6'b000000, 6'h3F, 1'b1, 8'h00, 1'b1},  // R3 modem, R7
        {6'b000000, 6'h3F, 1'b1, 8'h10, 1'b1},  // R3 special
        {6'b000000, 6'h3F, 1'b1, 8'h01, 1'b0},  // R4 empty
        {6'b010000, 6'h3F, 1'b0, 8'h00, 1'b1},  // R2 modem
        {6'b000001, 6'h3F, 1'b1, 8'h06, 1'b1},  // R5 line error during read
        {6'b000000, 6'h3F, 1'b1, 8'h01, 1'b0},  // R5 modem was cleared
        {6'b000100, 6'h3F, 1'b0, 8'h04, 1'b1},  // R2 rx data
        {6'b000100, 6'h3F, 1'b1, 8'h04, 1'b1},  // R9 set beats clear
        {6'b000000, 6'h3F, 1'b1, 8'h01, 1'b0},  // R9 then cleared
        {6'b000110, 6'h3B, 1'b0, 8'h0C, 1'b1},  // R6 rx data masked
        {6'b000000, 6'h3B, 1'b1, 8'h01, 1'b0},  // R6 masked not shown
        {6'b000000, 6'h3F, 1'b0, 8'h04, 1'b1},  // R6 latch kept
        {6'b000000, 6'h00, 1'b0, 8'h01, 1'b0},  // R6 all masked
        {6'b000000, 6'h00, 1'b1, 8'h01, 1'b0},  // R8 read with nothing shown
        {6'b000000, 6'h3F, 1'b0, 8'h04, 1'b1},  // R8 nothing was cleared
        {6'b000000, 6'h3F, 1'b1, 8'h01, 1'b0}   // R4 final clear
    };

    task automatic check(input string tag, input logic [7:0] es, input logic ei);
        checks++;
        if (stat !== es || irq !== ei) begin
            errors++;
            $display("FAIL %s: stat=%h irq=%b expected stat=%h irq=%b",
                     tag, stat, irq, es, ei);
        end
    endtask

    initial begin
        rst = 1'b1; req = '0; en = 6'h3F; rd = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset", 8'h01, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", 8'h01, 1'b0);

        for (int i = 0; i < NV; i++) begin
            req = VEC[i][21:16];
            en  = VEC[i][15:10];
            rd  = VEC[i][9];
            @(negedge clk);
            req = '0; rd = 1'b0;
            check($sformatf("R2-R9 vector %0d", i), VEC[i][8:1], VEC[i][0]);
        end

        // R1: reset while everything is pending
        en = 6'h3F; req = 6'h3F;
        @(negedge clk);
        req = '0;
        check("R3 all pending", 8'h06, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset clears pending", 8'h01, 1'b0);
        @(negedge clk);
        check("R1 stays idle", 8'h01, 1'b0);

        // R7: modem source reports code 0x00 with irq high
        req = 6'b010000;
        @(negedge clk);
        req = '0;
        check("R7 zero code with irq", 8'h00, 1'b1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule